// File: doc/BRIEF.md
# Sub-Audio Tone Match Decoder

This block classifies measured sub-audio tones. An upstream measurement stage delivers a 12-bit frequency code with a one-cycle valid strobe and a level qualifier that says a periodic tone is present. The block holds a table of up to fifteen programmed centre codes. It compares each measurement against every entry at once, within a tolerance window picked by a bandwidth select. The lowest-addressed matching entry gives the 4-bit tone number. A tone that is present but matches no entry is reported as tone number 4'hF.

Once a tone is decoded, the block keeps its decision and ignores later measurements. It leaves the decoded state only when the tone qualifier stays low for a full hold period, counted in clock cycles. If the tone comes back earlier, the hold period is cancelled and the tone number is kept. Clearing the enable forces the not-decoded state. A one-cycle change pulse marks every transition of the decode bit, so interrupt logic can pick it up.

Top module: `tone_match_decoder`

## Requirements
- R1: The table has 15 entries at addresses 0 to 14, each a 12-bit code. A write takes effect when `tbl_we` is high at a clock edge. A write to address 15 is ignored. Reset clears every entry to zero.
- R2: An entry holding 12'h000 never matches, even a measured code of zero.
- R3: A measured code m matches entry e when |m − e| × 1024 ≤ e × W. W is selected by `bw_sel[2:0]`: 0→11, 1→13, 2→16, 3→18, 4→20, 5→23, 6→26, 7→28. `bw_sel[3]` has no effect on matching.
- R4: When several entries match, the entry with the lowest address gives the tone number.
- R5: In the not-decoded state, with `enable` high, a cycle with both `meas_valid` and `tone_present` high sets `decoded` to 1 at the next clock edge. `tone_num` then equals the matching address, or 4'hF if no entry matches. A `meas_valid` with `tone_present` low is ignored.
- R6: While `decoded` is 1, further `meas_valid` strobes do not change `tone_num`.
- R7: While decoded, `decoded` falls to 0, and `tone_num` to 0, only after `tone_present` has been sampled low on HOLD_TICKS consecutive clock edges. A high sample before that point restarts the count and keeps the tone number.
- R8: With `enable` low, `decoded` is 0 and `tone_num` is 0 from the next clock edge, and measurements are ignored.
- R9: `change_pulse` is 1 in exactly those cycles where `decoded` differs from its value in the previous cycle.
- R10: During and right after reset, `decoded`, `tone_num` and `change_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Decoder enable; low forces the not-decoded state |
| bw_sel | input | 4 | Tolerance window select; bits [2:0] used |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 4 | Table write address |
| tbl_code | input | 12 | Table write data (centre code) |
| meas_valid | input | 1 | One-cycle strobe for a new measured code |
| meas_code | input | 12 | Measured frequency code |
| tone_present | input | 1 | Level qualifier: a periodic tone is present |
| decoded | output | 1 | Decode status bit |
| tone_num | output | 4 | Decoded tone number, 4'hF for an unlisted tone |
| change_pulse | output | 1 | One-cycle pulse on each change of `decoded` |

## Verification
The bench builds the block with the default fifteen entries and overrides HOLD_TICKS to 16. With that setting, the exact edge at which the hold period expires, and the cancel-and-restart case just short of it, can be checked within a few dozen cycles. The table is loaded with a zero entry, two overlapping entries, one upper entry and the highest address. This covers first-match priority, the unused-entry case and both ends of several tolerance windows. The bench also checks the code one step past each window edge, which must decode as 4'hF.

// File: rtl/tmd_pkg.sv
package tmd_pkg;
   localparam int CODE_W    = 12;
   localparam int WIN_SHIFT = 10;
   localparam int WIN_W     = 5;

   // Tolerance numerator over 2**WIN_SHIFT, about 1.1 % .. 2.7 %
   function automatic logic [WIN_W-1:0] win_num(input logic [2:0] sel);
      case (sel)
         3'd0:    win_num = 5'd11;
         3'd1:    win_num = 5'd13;
         3'd2:    win_num = 5'd16;
         3'd3:    win_num = 5'd18;
         3'd4:    win_num = 5'd20;
         3'd5:    win_num = 5'd23;
         3'd6:    win_num = 5'd26;
         default: win_num = 5'd28;
      endcase
   endfunction
endpackage

// File: rtl/tmd_table.sv
module tmd_table #(
   parameter int N_ENT  = 15,
   parameter int CODE_W = 12,
   parameter int IDX_W  = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we,
   input  logic [IDX_W-1:0]               addr,
   input  logic [CODE_W-1:0]              wdata,
   output logic [N_ENT-1:0][CODE_W-1:0]   entries
);
   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            entries[i] <= '0;
         else if (we && (addr == IDX_W'(i)))
            entries[i] <= wdata;
      end
   end
endmodule

// File: rtl/tmd_match.sv
module tmd_match #(
   parameter int N_ENT     = 15,
   parameter int CODE_W    = 12,
   parameter int IDX_W     = 4,
   parameter int WIN_W     = 5,
   parameter int WIN_SHIFT = 10
) (
   input  logic [N_ENT-1:0][CODE_W-1:0] entries,
   input  logic [CODE_W-1:0]            meas,
   input  logic [WIN_W-1:0]             win,
   output logic                         any_hit,
   output logic [IDX_W-1:0]             hit_idx
);
   localparam int PW = CODE_W + WIN_SHIFT;

   logic [N_ENT-1:0] hit;

   for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
      logic [CODE_W-1:0] diff;
      logic [PW-1:0]     lhs;
      logic [PW-1:0]     rhs;
      always_comb begin
         diff   = (meas >= entries[i]) ? (meas - entries[i]) : (entries[i] - meas);
         lhs    = PW'(diff) << WIN_SHIFT;
         rhs    = PW'(entries[i]) * PW'(win);
         hit[i] = (entries[i] != '0) && (lhs <= rhs);
      end
   end

   // Lowest address wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      any_hit = 1'b0;
      hit_idx = '1;
      for (int i = N_ENT - 1; i >= 0; i--) begin
         if (hit[i]) begin
            any_hit = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/tmd_state.sv
module tmd_state #(
   parameter int IDX_W      = 4,
   parameter int HOLD_TICKS = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             meas_valid,
   input  logic             tone_present,
   input  logic             any_hit,
   input  logic [IDX_W-1:0] hit_idx,
   output logic             decoded,
   output logic [IDX_W-1:0] tone_num,
   output logic             change_pulse
);
   localparam int CNT_W = (HOLD_TICKS > 2) ? $clog2(HOLD_TICKS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

   logic             dec_q, dec_n;
   logic [IDX_W-1:0] num_q, num_n;
   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             pls_q;

   always_comb begin
      dec_n = dec_q;
      num_n = num_q;
      cnt_n = cnt_q;
      if (!enable) begin
         dec_n = 1'b0;
         num_n = '0;
         cnt_n = '0;
      end else if (!dec_q) begin
         cnt_n = '0;
         if (meas_valid && tone_present) begin
            dec_n = 1'b1;
            num_n = any_hit ? hit_idx : '1;
         end
      end else if (tone_present) begin
         cnt_n = '0;
      end else if (cnt_q == CNT_LAST) begin
         dec_n = 1'b0;
         num_n = '0;
         cnt_n = '0;
      end else begin
         cnt_n = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_q <= 1'b0;
         num_q <= '0;
         cnt_q <= '0;
         pls_q <= 1'b0;
      end else begin
         dec_q <= dec_n;
         num_q <= num_n;
         cnt_q <= cnt_n;
         pls_q <= dec_n ^ dec_q;
      end
   end

   assign decoded      = dec_q;
   assign tone_num     = num_q;
   assign change_pulse = pls_q;
endmodule

// File: rtl/tone_match_decoder.sv
module tone_match_decoder #(
   parameter int N_ENTRIES  = 15,
   parameter int HOLD_TICKS = 4000,
   localparam int IDX_W     = $clog2(N_ENTRIES + 1),
   localparam int CODE_W    = tmd_pkg::CODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [3:0]        bw_sel,
   input  logic              tbl_we,
   input  logic [IDX_W-1:0]  tbl_addr,
   input  logic [CODE_W-1:0] tbl_code,
   input  logic              meas_valid,
   input  logic [CODE_W-1:0] meas_code,
   input  logic              tone_present,
   output logic              decoded,
   output logic [IDX_W-1:0]  tone_num,
   output logic              change_pulse
);
   initial begin
      assert (N_ENTRIES >= 1 && N_ENTRIES < (1 << IDX_W))
         else $error("N_ENTRIES must leave one code free for unlisted tones");
      assert (HOLD_TICKS >= 2)
         else $error("HOLD_TICKS must be at least 2");
   end

   logic [N_ENTRIES-1:0][CODE_W-1:0] entries;
   logic                             any_hit;
   logic [IDX_W-1:0]                 hit_idx;
   logic [tmd_pkg::WIN_W-1:0]        win;

   assign win = tmd_pkg::win_num(bw_sel[2:0]);

   tmd_table #(.N_ENT(N_ENTRIES), .CODE_W(CODE_W), .IDX_W(IDX_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (tbl_we),
      .addr    (tbl_addr),
      .wdata   (tbl_code),
      .entries (entries)
   );

   tmd_match #(
      .N_ENT(N_ENTRIES), .CODE_W(CODE_W), .IDX_W(IDX_W),
      .WIN_W(tmd_pkg::WIN_W), .WIN_SHIFT(tmd_pkg::WIN_SHIFT)
   ) u_match (
      .entries (entries),
      .meas    (meas_code),
      .win     (win),
      .any_hit (any_hit),
      .hit_idx (hit_idx)
   );

   tmd_state #(.IDX_W(IDX_W), .HOLD_TICKS(HOLD_TICKS)) u_state (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .meas_valid   (meas_valid),
      .tone_present (tone_present),
      .any_hit      (any_hit),
      .hit_idx      (hit_idx),
      .decoded      (decoded),
      .tone_num     (tone_num),
      .change_pulse (change_pulse)
   );
endmodule

// File: rtl/tmd_checker.sv
module tmd_checker #(
   parameter int IDX_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             meas_valid,
   input logic             tone_present,
   input logic             decoded,
   input logic [IDX_W-1:0] tone_num,
   input logic             change_pulse
);
   p_disable_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!decoded && tone_num == '0));

   p_pulse_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (decoded != $past(decoded)) |-> change_pulse);

   p_pulse_only_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      change_pulse |-> (decoded != $past(decoded)));

   p_rise_needs_tone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(decoded) |-> $past(enable && meas_valid && tone_present));

   p_num_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (decoded && $past(decoded)) |-> $stable(tone_num));

   p_fall_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(decoded) |-> ($past(!enable) || $past(!tone_present)));
endmodule

bind tone_match_decoder tmd_checker #(.IDX_W(IDX_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enable       (enable),
   .meas_valid   (meas_valid),
   .tone_present (tone_present),
   .decoded      (decoded),
   .tone_num     (tone_num),
   .change_pulse (change_pulse)
);

// File: tb/tone_match_decoder_tb.sv
`timescale 1ns/1ps
module tone_match_decoder_tb;
   localparam int HOLD = 16;
   localparam int NV   = 14;

   // {bw_sel[3:0], meas_code[11:0], expected tone_num[3:0]}
   // Table: 0 -> 0 (unused), 1 -> 1000, 2 -> 1010, 3 -> 2000, 14 -> 3000; write to 15 = 500 ignored
   localparam logic [19:0] VEC [NV] = '{
      {4'h8, 12'd1000, 4'h1},  // R4 both 1 and 2 match, lowest wins
      {4'h8, 12'd1015, 4'h2},  // R3
      {4'h8, 12'd1025, 4'hF},  // R3 outside narrowest window
      {4'hF, 12'd1025, 4'h1},  // R3 widest window
      {4'h8, 12'd2021, 4'h3},  // R3 upper edge
      {4'h8, 12'd2022, 4'hF},  // R3 one past upper edge
      {4'h8, 12'd1979, 4'h3},  // R3 lower edge
      {4'h8, 12'd3000, 4'hE},  // R1 highest address
      {4'h8, 12'd0,    4'hF},  // R2 zero entry never matches
      {4'h0, 12'd1025, 4'hF},  // R3 bw_sel[3] no effect
      {4'h7, 12'd1025, 4'h1},  // R3 bw_sel[3] no effect
      {4'hB, 12'd2035, 4'h3},  // R3 window 18 edge
      {4'hB, 12'd2036, 4'hF},  // R3 window 18 past edge
      {4'h8, 12'd500,  4'hF}   // R1 address 15 write ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic [3:0]  bw_sel = 4'h8;
   logic        tbl_we = 1'b0;
   logic [3:0]  tbl_addr = '0;
   logic [11:0] tbl_code = '0;
   logic        meas_valid = 1'b0;
   logic [11:0] meas_code = '0;
   logic        tone_present = 1'b0;
   logic        decoded;
   logic [3:0]  tone_num;
   logic        change_pulse;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   tone_match_decoder #(.N_ENTRIES(15), .HOLD_TICKS(HOLD)) u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bw_sel(bw_sel),
      .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_code(tbl_code),
      .meas_valid(meas_valid), .meas_code(meas_code), .tone_present(tone_present),
      .decoded(decoded), .tone_num(tone_num), .change_pulse(change_pulse)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [11:0] c);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = a; tbl_code = c;
      @(negedge clk);
      tbl_we = 1'b0;
   endtask

   // Strobe one measurement with the tone present; returns after the capturing edge
   task automatic strobe(input logic [11:0] c);
      meas_valid = 1'b1; tone_present = 1'b1; meas_code = c;
      @(negedge clk);
      meas_valid = 1'b0;
   endtask

   task automatic lose_full();
      tone_present = 1'b0;
      repeat (HOLD) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 decoded in reset", decoded, 0);
      chk("R10 tone_num in reset", tone_num, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 decoded after reset", decoded, 0);
      chk("R10 pulse after reset", change_pulse, 0);

      wr(4'd1, 12'd1000);
      wr(4'd2, 12'd1010);
      wr(4'd3, 12'd2000);
      wr(4'd14, 12'd3000);
      wr(4'd15, 12'd500);
      enable = 1'b1;
      @(negedge clk);

      // Vector walk
      for (int v = 0; v < NV; v++) begin
         bw_sel = VEC[v][19:16];
         strobe(VEC[v][15:4]);
         chk("R5 decoded after strobe", decoded, 1);
         chk("R3/R4 tone_num", tone_num, VEC[v][3:0]);
         chk("R9 pulse on rise", change_pulse, 1);
         lose_full();
         chk("R7 decoded after hold", decoded, 0);
         chk("R9 pulse on fall", change_pulse, 1);
         @(negedge clk);
      end
      bw_sel = 4'h8;

      // R5: strobe without tone_present is ignored
      meas_valid = 1'b1; meas_code = 12'd1000; tone_present = 1'b0;
      @(negedge clk);
      meas_valid = 1'b0;
      chk("R5 no tone_present ignored", decoded, 0);
      chk("R9 no pulse without change", change_pulse, 0);

      // R6: measurements ignored while decoded
      strobe(12'd1000);
      chk("R5 decode 1000", tone_num, 1);
      @(negedge clk);
      chk("R9 pulse single cycle", change_pulse, 0);
      meas_valid = 1'b1; meas_code = 12'd3000;
      @(negedge clk);
      meas_valid = 1'b0;
      chk("R6 tone_num kept", tone_num, 1);

      // R7: loss shorter than the hold, then recovery and full loss
      tone_present = 1'b0;
      repeat (HOLD - 1) @(negedge clk);
      chk("R7 still decoded before expiry", decoded, 1);
      tone_present = 1'b1;
      @(negedge clk);
      tone_present = 1'b0;
      repeat (HOLD - 1) @(negedge clk);
      chk("R7 timer restarted", decoded, 1);
      chk("R7 tone_num kept over gap", tone_num, 1);
      @(negedge clk);
      chk("R7 drop at expiry", decoded, 0);
      chk("R7 tone_num cleared", tone_num, 0);

      // R8: enable low forces not-decoded and blocks strobes
      @(negedge clk);
      strobe(12'd2000);
      chk("R5 decode 2000", tone_num, 3);
      enable = 1'b0;
      @(negedge clk);
      chk("R8 decoded cleared", decoded, 0);
      chk("R8 tone_num cleared", tone_num, 0);
      chk("R9 pulse on disable", change_pulse, 1);
      strobe(12'd2000);
      chk("R8 strobe ignored while disabled", decoded, 0);
      enable = 1'b1;
      tone_present = 1'b0;
      @(negedge clk);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule